// File: doc/BRIEF.md
# Serial Page-Flash Command Sequencer

This block sits on the host side of a four-wire SPI link to a serial flash. The flash is organized in 528-byte pages. The host sends one command at a time over a request/acknowledge handshake. Each command names an operation, a page number and a byte-in-page offset. The block then builds the serial frame: opcode, 24-bit address and any don't-care filler. It clocks the frame out and returns read bytes on a valid/ready stream.

After each program or erase, the block holds off new requests. During that time it repeatedly reads the device status byte until the ready bit is set, or until a host-set number of attempts has run out. Right after reset, it reads status once on its own and reports whether the density field matches the expected device size.

Top module: `spi_page_flash_ctrl`

## Requirements
- R1: While reset is held, `spi_cs_n` is 1, `spi_sck` is 0 and `req_ready` is 0. `req_ready` stays 0 after reset until the automatic status read has finished.
- R2: The automatic status read after reset sets `density_err` to 1 exactly when status bits [5:3] differ from 3'b101.
- R3: The link uses SPI mode 0. SCK idles low while chip select is high. Every field is shifted MSB first. Each SCK level lasts DIV system clocks (2 by default, giving 12.5 MHz from 50 MHz).
- R4: `req_cmd`=0 (page read) sends 0x52, then the 24-bit address {2'b00, page[11:0], byte[9:0]}, then 32 zero bits, and then streams bytes from the device.
- R5: A byte offset above 527 is sent as 527.
- R6: `req_cmd`=1 and 2 (buffer reads) send 0x54 and 0x56 respectively. The address carries the byte offset in its low 10 bits, with zeros above it. Eight zero bits follow before the data.
- R7: `req_cmd`=3 sends 0x89 (program from buffer 2, no erase) and `req_cmd`=4 sends 0x81 (page erase). Both use address {2'b00, page, 10'b0}. `req_cmd`=5 sends 0x50 (block erase) with page[2:0] forced to 0. Each of these frames is exactly 32 bits long.
- R8: After a program or erase, the block issues status reads (opcode 0x57, one byte back) until bit 7 of the status byte is 1. During this time `req_ready` stays 0.
- R9: If `poll_limit` status reads all return not-ready, the block sets `timeout_err` and stops polling. Accepting the next command clears `timeout_err`.
- R10: Chip select stays high for at least GAP (default 2) system clocks between frames.
- R11: While `rd_valid` is 1 and `rd_ready` is 0, `rd_data` holds its value and SCK stays low.
- R12: A read ends at the byte that is accepted with `rd_stop`=1, and chip select rises after it. `req_cmd`=6 or 7 (status read) returns exactly one byte and then ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Command request |
| req_ready | output | 1 | Block idle and able to take a command |
| req_cmd | input | 3 | Operation code (see R4 to R12) |
| req_page | input | PW | Page number |
| req_byte | input | BW | Byte offset in page or buffer |
| poll_limit | input | TW | Maximum number of status reads after program or erase |
| rd_data | output | 8 | Read byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Host takes the read byte |
| rd_stop | input | 1 | The byte taken is the last one |
| density_err | output | 1 | Density field mismatch found after reset |
| timeout_err | output | 1 | Busy polling ran out of attempts |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
Some properties are checked on every cycle: SCK stays low while deselected, each SCK level lasts its full length, chip select keeps its minimum high gap, a stalled read byte stays unchanged, and the block stays unready while polling. The bench uses a behavioural flash model that decodes every frame. Only its scenarios can show that opcodes, addresses, offset clamping, filler length, byte streaming, early stop, poll counts, the timeout and the density comparison are correct.

// File: rtl/spi_page_flash_ctrl.sv
module spi_page_flash_ctrl #(
  parameter int DIV  = 2,
  parameter int GAP  = 2,
  parameter int PW   = 12,
  parameter int BW   = 10,
  parameter int BMAX = 527,
  parameter int TW   = 16
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_cmd,
  input  logic [PW-1:0] req_page,
  input  logic [BW-1:0] req_byte,
  input  logic [TW-1:0] poll_limit,
  output logic [7:0]    rd_data,
  output logic          rd_valid,
  input  logic          rd_ready,
  input  logic          rd_stop,
  output logic          density_err,
  output logic          timeout_err,
  output logic          spi_cs_n,
  output logic          spi_sck,
  output logic          spi_mosi,
  input  logic          spi_miso
);
  localparam int AW = 2 + PW + BW;
  localparam int SW = 8 + AW + 32;
  localparam int CW = $clog2(DIV + 1);
  localparam int GW = $clog2(GAP + 1);
  localparam int HW = $clog2(SW + 1);

  typedef enum logic [1:0] {ST_GAP, ST_IDLE, ST_SHIFT, ST_HOLD} st_t;
  typedef enum logic [1:0] {K_HOST, K_POLL, K_BOOT} kind_t;

  st_t           st;
  kind_t         kind, l_kind;
  logic [CW-1:0] dcnt;
  logic [GW-1:0] gcnt;
  logic [SW-1:0] sr, frm, l_frm;
  logic [HW-1:0] hleft, frm_n, l_n;
  logic [2:0]    rbit;
  logic [7:0]    rsr;
  logic [TW-1:0] pcnt;
  logic          has_rx, single, boot_pend, poll_pend;
  logic          frm_rx, l_rx, l_single, launch, tick;
  logic [BW-1:0] byte_c;

  assign req_ready = (st == ST_IDLE);
  assign spi_mosi  = sr[SW-1];
  assign tick      = (dcnt == CW'(DIV - 1));
  assign byte_c    = (req_byte > BW'(BMAX)) ? BW'(BMAX) : req_byte;

  always_comb begin
    frm = '0; frm_n = HW'(8 + AW); frm_rx = 1'b0;
    case (req_cmd)
      3'd0: begin frm = {8'h52, 2'b00, req_page, byte_c, 32'h0}; frm_n = HW'(SW); frm_rx = 1'b1; end
      3'd1, 3'd2: begin
        frm = {(req_cmd[1] ? 8'h56 : 8'h54), {(2 + PW){1'b0}}, byte_c, 32'h0};
        frm_n = HW'(8 + AW + 8); frm_rx = 1'b1;
      end
      3'd3: frm = {8'h89, 2'b00, req_page, {BW{1'b0}}, 32'h0};
      3'd4: frm = {8'h81, 2'b00, req_page, {BW{1'b0}}, 32'h0};
      3'd5: frm = {8'h50, 2'b00, req_page[PW-1:3], 3'b000, {BW{1'b0}}, 32'h0};
      default: begin frm = {8'h57, {(AW + 32){1'b0}}}; frm_n = HW'(8); frm_rx = 1'b1; end
    endcase
  end

  always_comb begin
    launch = 1'b0; l_frm = frm; l_n = frm_n; l_rx = frm_rx;
    l_single = (req_cmd[2:1] == 2'b11); l_kind = K_HOST;
    if (st == ST_IDLE && req_valid) launch = 1'b1;
    else if (st == ST_GAP && gcnt == GW'(GAP - 1) && (boot_pend || poll_pend)) begin
      launch = 1'b1; l_frm = {8'h57, {(AW + 32){1'b0}}}; l_n = HW'(8);
      l_rx = 1'b1; l_single = 1'b1; l_kind = boot_pend ? K_BOOT : K_POLL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_GAP; kind <= K_HOST; dcnt <= '0; gcnt <= '0; sr <= '0; hleft <= '0;
      rbit <= '0; rsr <= '0; pcnt <= '0; has_rx <= 1'b0; single <= 1'b0;
      boot_pend <= 1'b1; poll_pend <= 1'b0; rd_data <= '0; rd_valid <= 1'b0;
      density_err <= 1'b0; timeout_err <= 1'b0; spi_cs_n <= 1'b1; spi_sck <= 1'b0;
    end else if (launch) begin
      st <= ST_SHIFT; spi_cs_n <= 1'b0; spi_sck <= 1'b0; sr <= l_frm; hleft <= l_n;
      has_rx <= l_rx; single <= l_single; kind <= l_kind; dcnt <= '0; rbit <= '0;
      if (st == ST_IDLE) timeout_err <= 1'b0;
    end else begin
      case (st)
        ST_GAP: if (gcnt == GW'(GAP - 1)) st <= ST_IDLE; else gcnt <= gcnt + 1'b1;
        ST_SHIFT: begin
          dcnt <= tick ? '0 : dcnt + 1'b1;
          if (tick) begin
            spi_sck <= ~spi_sck;
            if (!spi_sck) rsr <= {rsr[6:0], spi_miso};
            else begin
              sr <= sr << 1;
              if (hleft != '0) begin
                hleft <= hleft - 1'b1;
                if (hleft == HW'(1) && !has_rx) begin
                  poll_pend <= 1'b1; pcnt <= '0;
                  st <= ST_GAP; gcnt <= '0; spi_cs_n <= 1'b1;
                end
              end else begin
                rbit <= rbit + 1'b1;
                if (rbit == 3'd7) begin
                  case (kind)
                    K_BOOT: begin
                      density_err <= (rsr[5:3] != 3'b101); boot_pend <= 1'b0;
                      st <= ST_GAP; gcnt <= '0; spi_cs_n <= 1'b1;
                    end
                    K_POLL: begin
                      pcnt <= pcnt + 1'b1;
                      if (rsr[7]) poll_pend <= 1'b0;
                      else if ((pcnt + TW'(1)) >= poll_limit) begin
                        poll_pend <= 1'b0; timeout_err <= 1'b1;
                      end
                      st <= ST_GAP; gcnt <= '0; spi_cs_n <= 1'b1;
                    end
                    default: begin rd_data <= rsr; rd_valid <= 1'b1; st <= ST_HOLD; end
                  endcase
                end
              end
            end
          end
        end
        ST_HOLD: if (rd_ready) begin
          rd_valid <= 1'b0;
          if (rd_stop || single) begin st <= ST_GAP; gcnt <= '0; spi_cs_n <= 1'b1; end
          else begin st <= ST_SHIFT; dcnt <= '0; end
        end
        default: ;
      endcase
    end
  end

  logic [3:0] cs_hi, sck_age;
  logic       sck_prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin cs_hi <= '0; sck_age <= '0; sck_prev <= 1'b0; end
    else begin
      cs_hi    <= !spi_cs_n ? '0 : (cs_hi == 4'hF ? cs_hi : cs_hi + 1'b1);
      sck_age  <= (spi_sck != sck_prev) ? '0 : (sck_age == 4'hF ? sck_age : sck_age + 1'b1);
      sck_prev <= spi_sck;
    end
  end

  assert_sck_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);
  assert_sck_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck != sck_prev) |-> (sck_age >= 4'(DIV - 1)));
  assert_cs_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> (cs_hi >= 4'(GAP)));
  assert_hold_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && !spi_sck));
  assert_poll_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    poll_pend |-> !req_ready);
endmodule

// File: tb/spi_page_flash_ctrl_tb.sv
module spi_page_flash_ctrl_tb_top;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, rd_ready = 0, rd_stop = 0, miso = 0;
  logic [2:0] req_cmd = 0;
  logic [11:0] req_page = 0;
  logic [9:0] req_byte = 0;
  logic [15:0] poll_limit = 16'd100;
  logic req_ready, rd_valid, density_err, timeout_err, cs_n, sck, mosi;
  logic [7:0] rd_data;

  spi_page_flash_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_page(req_page), .req_byte(req_byte), .poll_limit(poll_limit),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_stop(rd_stop),
    .density_err(density_err), .timeout_err(timeout_err),
    .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi), .spi_miso(miso));

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // behavioural flash model
  logic [63:0] in_sr = 0;
  logic [7:0]  s_op = 0, last_op = 0;
  logic [23:0] s_addr = 0, last_addr = 0;
  logic [2:0]  dens = 3'b101;
  int s_n = 0, last_n = 0, stat_frames = 0, busy_left = 0, busy_polls = 0;

  function automatic int hdr_of(input logic [7:0] op);
    case (op)
      8'h52: return 64;
      8'h54, 8'h56: return 40;
      8'h57: return 8;
      default: return 1000;
    endcase
  endfunction

  function automatic logic [7:0] data_of(input int k);
    case (s_op)
      8'h52: return s_addr[17:10] + s_addr[7:0] + 8'(k);
      8'h54: return 8'hA0 + s_addr[7:0] + 8'(k);
      8'h56: return 8'hC0 + s_addr[7:0] + 8'(k);
      default: return {busy_left == 0, 1'b0, dens, 3'b000};
    endcase
  endfunction

  initial forever begin
    @(negedge cs_n);
    s_n = 0; s_op = 0; s_addr = 0;
    forever begin
      @(posedge sck or posedge cs_n);
      if (cs_n) break;
      in_sr = {in_sr[62:0], mosi}; s_n++;
      if (s_n == 8) s_op = in_sr[7:0];
      if (s_n == 32) s_addr = in_sr[23:0];
      @(negedge sck or posedge cs_n);
      if (cs_n) break;
      if (s_n >= hdr_of(s_op)) begin
        automatic int idx = s_n - hdr_of(s_op);
        automatic logic [7:0] b = data_of(idx / 8);
        miso = b[7 - (idx % 8)];
      end
    end
    if (s_op == 8'h57) begin
      stat_frames++;
      if (busy_left > 0) busy_left--;
    end else begin
      last_op = s_op; last_addr = s_addr; last_n = s_n;
      if (s_op == 8'h89 || s_op == 8'h81 || s_op == 8'h50) busy_left = busy_polls;
    end
  end

  // link timing monitor
  int sck_run = 0, min_sck = 1000, cs_run = 0, min_cs = 1000;
  logic sck_last = 0, cs_last = 1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (sck == sck_last) sck_run++;
      else begin if (sck_run < min_sck) min_sck = sck_run; sck_run = 1; end
      if (cs_n) cs_run++;
      else begin if (cs_last && cs_run < min_cs) min_cs = cs_run; cs_run = 0; end
    end else begin sck_run = 0; cs_run = 0; end
    sck_last = sck; cs_last = cs_n;
  end

  task automatic wait_idle();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
  endtask

  task automatic issue(input logic [2:0] c, input logic [11:0] pg, input logic [9:0] by);
    while (!req_ready) @(negedge clk);
    req_cmd = c; req_page = pg; req_byte = by; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  logic [7:0] got [4];
  logic stall_ok;
  task automatic host_read(input logic [2:0] c, input logic [11:0] pg, input logic [9:0] by,
                           input int n, input int stall);
    issue(c, pg, by);
    stall_ok = 1;
    for (int i = 0; i < n; i++) begin
      while (!rd_valid) @(negedge clk);
      got[i] = rd_data;
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        if (sck !== 1'b0 || cs_n !== 1'b0 || rd_valid !== 1'b1 || rd_data !== got[i]) stall_ok = 0;
      end
      rd_stop = (i == n - 1); rd_ready = 1;
      @(negedge clk);
      rd_ready = 0; rd_stop = 0;
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 cs_n in reset", cs_n, 1);
    chk("R1 sck in reset", sck, 0);
    chk("R1 ready in reset", req_ready, 0);
    stat_frames = 0;
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk("R1 not ready during boot read", req_ready, 0);
    wait_idle();
    chk("R1 boot status read issued", stat_frames, 1);
  endtask

  localparam logic [64:0] VEC [9] = '{
    {3'd0, 12'h123, 10'h005, 8'h52, 24'h048C05, 8'h28},
    {3'd0, 12'hFFF, 10'h20F, 8'h52, 24'h3FFE0F, 8'h0E},
    {3'd0, 12'h001, 10'h384, 8'h52, 24'h00060F, 8'h10},
    {3'd1, 12'h555, 10'h010, 8'h54, 24'h000010, 8'hB0},
    {3'd2, 12'h000, 10'h1FF, 8'h56, 24'h0001FF, 8'hBF},
    {3'd3, 12'h0AB, 10'h3FF, 8'h89, 24'h02AC00, 8'h00},
    {3'd4, 12'h800, 10'h001, 8'h81, 24'h200000, 8'h00},
    {3'd5, 12'h7FF, 10'h0AA, 8'h50, 24'h1FE000, 8'h00},
    {3'd6, 12'h000, 10'h000, 8'h57, 24'h000000, 8'hA8}
  };

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R1-R12 run act=hung exp=finished");
    summary();
    $finish;
  end

  initial begin
    do_reset();
    chk("R2 density match", density_err, 0);

    for (int i = 0; i < 9; i++) begin
      automatic logic [64:0] v = VEC[i];
      busy_polls = 2; stat_frames = 0;
      if (v[64:62] <= 3'd2) begin
        host_read(v[64:62], v[61:50], v[49:40], 3, 0);
        wait_idle();
        chk("R4 R6 opcode", last_op, v[39:32]);
        chk("R4 R5 R6 address", last_addr, v[31:8]);
        chk("R4 R6 byte 0", got[0], v[7:0]);
        chk("R4 R6 byte 2", got[2], v[7:0] + 8'd2);
        chk("R12 frame ends after third byte", last_n, (v[64:62] == 3'd0 ? 64 : 40) + 24);
      end else if (v[64:62] <= 3'd5) begin
        issue(v[64:62], v[61:50], v[49:40]);
        wait_idle();
        chk("R7 opcode", last_op, v[39:32]);
        chk("R7 address", last_addr, v[31:8]);
        chk("R7 frame length", last_n, 32);
        chk("R8 polls until ready", stat_frames, 3);
        chk("R9 no timeout", timeout_err, 0);
      end else begin
        host_read(v[64:62], 12'h0, 10'h0, 1, 0);
        wait_idle();
        chk("R12 status byte", got[0], v[7:0]);
        chk("R12 single status frame", stat_frames, 1);
      end
    end

    // poll timeout and clear on next command
    poll_limit = 16'd3; busy_polls = 10; stat_frames = 0;
    issue(3'd4, 12'h010, 10'h0);
    wait_idle();
    chk("R9 timeout flag", timeout_err, 1);
    chk("R9 poll attempts", stat_frames, 3);
    busy_left = 0; poll_limit = 16'd100;
    host_read(3'd6, 12'h0, 10'h0, 1, 0);
    wait_idle();
    chk("R9 flag cleared by next command", timeout_err, 0);

    // stalled read stream
    host_read(3'd0, 12'h042, 10'h011, 2, 20);
    wait_idle();
    chk("R11 held byte and idle sck", stall_ok, 1);
    chk("R11 byte 0 after stall", got[0], 8'h53);
    chk("R11 byte 1 after stall", got[1], 8'h54);

    // density mismatch after reset, then restore
    dens = 3'b111;
    do_reset();
    chk("R2 density mismatch", density_err, 1);
    dens = 3'b101;
    do_reset();
    chk("R2 density restored", density_err, 0);

    chk("R3 sck half period", min_sck, 2);
    chk("R10 cs high gap", min_cs >= 2, 1);

    summary();
    $finish;
  end
endmodule